// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block owns the status register of a 128 KB serial EEPROM and decides, cycle by cycle, whether a pending write may go ahead. The command front end (serial shifting and opcode decode) presents two kinds of request: a status-register update with its data byte, or an array write with its 17-bit target address. The block answers each one with a combinational permit. The front end issues the write only when the matching permit is high.

The block holds three pieces of state: the write-enable latch, a two-bit protection level and a pin-enable flag. The protection level fences off the top quarter of the array, the top half, or all of it. The pin-enable flag works together with the active-low write-protect pin to freeze the status register. Once the flag is set and the pin is low, the register stays frozen, and the flag cannot be removed until the pin goes high again. A read of the status byte shows the live busy flag and all of the stored state.

Top module: `eewp_ctrl`

## Requirements
- R1: After reset, the write-enable latch, both protection-level bits and the pin-enable flag are 0.
- R2: Status byte layout: bit 0 mirrors `busy_i`, bit 1 is the write-enable latch, bits 3:2 are the protection level (bit 3 high-order), bit 7 is the pin-enable flag, and bits 6:4 always read 0.
- R3: A `wel_set_i` pulse sets the write-enable latch at the next clock edge. A `wel_clr_i` pulse clears it. When both are high in the same cycle, the clear wins.
- R4: Protection level 00 protects no address. Level 01 protects 18000h–1FFFFh. Level 10 protects 10000h–1FFFFh. Level 11 protects the whole array. An array write to a protected address is never permitted.
- R5: An array write to an unprotected address is permitted exactly when the write-enable latch is 1, whatever the level of the write-protect pin.
- R6: Hardware lock is active only while `wp_n_i` is 0 and the pin-enable flag is 1. While it is active, status writes are refused even with the write-enable latch set.
- R7: A status write is permitted when the latch is 1 and the hardware lock is inactive. At the next edge, the protection level takes data bits 3:2 and the pin-enable flag takes data bit 7. The other data bits have no effect.
- R8: While `wp_n_i` is 0, a pin-enable flag that is 1 stays 1.
- R9: An accepted write of either kind clears the write-enable latch. A refused write leaves the latch, the protection level and the pin-enable flag unchanged.
- R10: When a status write and an array write are requested in the same cycle, the array permit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| wel_set_i | input | 1 | Set the write-enable latch |
| wel_clr_i | input | 1 | Clear the write-enable latch |
| sr_wr_req_i | input | 1 | Status-register write request |
| sr_wr_data_i | input | 8 | Byte offered for the status register |
| arr_wr_req_i | input | 1 | Array write request |
| arr_addr_i | input | 17 | Byte address of the array write |
| status_o | output | 8 | Status byte for reads |
| sr_wr_ok_o | output | 1 | Status write permitted |
| arr_wr_ok_o | output | 1 | Array write permitted |

## Verification
The bound checker watches the following on every clock:
- No permit is ever granted without the latch.
- No status permit is granted while the lock is active.
- No array permit is granted at the full-array level or when both requests are present.
- The pin-enable flag never falls while the pin is low.
- The latch always drops after an accepted write.
- The unused status bits stay 0.

Only the bench's scenarios can show the rest. These are the exact boundary addresses of each protection level, the values captured from a status write, the set/clear priority of the latch, and the fact that a refused write leaves every stored field as it was.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
   localparam int SR_W     = 8;
   localparam int BUSY_BIT = 0;
   localparam int WEL_BIT  = 1;
   localparam int LVL_LO   = 2;
   localparam int LVL_HI   = 3;
   localparam int PEN_BIT  = 7;

   typedef enum logic [1:0] {
      LVL_NONE = 2'b00,
      LVL_QTR  = 2'b01,
      LVL_HALF = 2'b10,
      LVL_ALL  = 2'b11
   } prot_lvl_e;

   typedef struct packed {
      logic      pen;
      prot_lvl_e lvl;
   } prot_state_t;
endpackage

// File: rtl/eewp_range_decode.sv
module eewp_range_decode
   import eewp_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  prot_lvl_e         lvl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam int MSB = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("eewp_range_decode: ADDR_W must be at least 2");
      end
   endgenerate

   logic [1:0] top_bits;
   assign top_bits = addr_i[MSB -: 2];

   always_comb begin
      unique case (lvl_i)
         LVL_NONE: hit_o = 1'b0;
         LVL_QTR:  hit_o = (top_bits == 2'b11);
         LVL_HALF: hit_o = top_bits[1];
         default:  hit_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/eewp_prot_reg.sv
module eewp_prot_reg
   import eewp_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [SR_W-1:0] wr_data_i,
   input  logic            pin_low_i,
   output prot_state_t     state_o
);
   prot_state_t nxt;

   always_comb begin
      nxt = state_o;
      if (wr_en_i) begin
         nxt.lvl = prot_lvl_e'(wr_data_i[LVL_HI:LVL_LO]);
         // flag is sticky while the pin is held low
         nxt.pen = wr_data_i[PEN_BIT] | (state_o.pen & pin_low_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= '{pen: 1'b0, lvl: LVL_NONE};
      else        state_o <= nxt;
   end
endmodule

// File: rtl/eewp_wel.sv
module eewp_wel (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic consume_i,
   output logic wel_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 wel_o <= 1'b0;
      else if (consume_i || clr_i) wel_o <= 1'b0;
      else if (set_i)              wel_o <= 1'b1;
   end
endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl
   import eewp_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n_i,
   input  logic              busy_i,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              sr_wr_req_i,
   input  logic [SR_W-1:0]   sr_wr_data_i,
   input  logic              arr_wr_req_i,
   input  logic [ADDR_W-1:0] arr_addr_i,
   output logic [SR_W-1:0]   status_o,
   output logic              sr_wr_ok_o,
   output logic              arr_wr_ok_o
);
   generate
      if (SR_W != 8) begin : g_bad_sr
         $error("eewp_ctrl: status register must be 8 bits");
      end
   endgenerate

   prot_state_t ps;
   logic        wel;
   logic        in_range;
   logic        hw_lock;

   assign hw_lock     = ~wp_n_i & ps.pen;
   assign sr_wr_ok_o  = sr_wr_req_i & wel & ~hw_lock;
   assign arr_wr_ok_o = arr_wr_req_i & ~sr_wr_req_i & wel & ~in_range;

   eewp_range_decode #(.ADDR_W(ADDR_W)) u_range (
      .lvl_i  (ps.lvl),
      .addr_i (arr_addr_i),
      .hit_o  (in_range)
   );

   eewp_prot_reg u_prot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (sr_wr_ok_o),
      .wr_data_i (sr_wr_data_i),
      .pin_low_i (~wp_n_i),
      .state_o   (ps)
   );

   eewp_wel u_wel (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (wel_set_i),
      .clr_i     (wel_clr_i),
      .consume_i (sr_wr_ok_o | arr_wr_ok_o),
      .wel_o     (wel)
   );

   always_comb begin
      status_o                 = '0;
      status_o[BUSY_BIT]       = busy_i;
      status_o[WEL_BIT]        = wel;
      status_o[LVL_HI:LVL_LO]  = ps.lvl;
      status_o[PEN_BIT]        = ps.pen;
   end
endmodule

// File: rtl/eewp_ctrl_chk.sv
module eewp_ctrl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wp_n_i,
   input logic              busy_i,
   input logic              wel_set_i,
   input logic              wel_clr_i,
   input logic              sr_wr_req_i,
   input logic [7:0]        sr_wr_data_i,
   input logic              arr_wr_req_i,
   input logic [ADDR_W-1:0] arr_addr_i,
   input logic [7:0]        status_o,
   input logic              sr_wr_ok_o,
   input logic              arr_wr_ok_o
);
   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (status_o[7:1] == 7'd0));

   // R2
   spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6:4] == 3'd0);

   // R6
   locked_sr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n_i && status_o[7]) |-> !sr_wr_ok_o);

   // R7
   sr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_ok_o |-> status_o[1]);

   // R5
   arr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_ok_o |-> status_o[1]);

   // R4
   full_lock_arr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);

   // R8
   pen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n_i && status_o[7]) |=> status_o[7]);

   // R9
   wel_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_ok_o || arr_wr_ok_o) |=> !status_o[1]);

   // R10
   sr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_req_i |-> !arr_wr_ok_o);
endmodule

bind eewp_ctrl eewp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/eewp_ctrl_bench.sv
module eewp_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp_n_i = 1'b1;
   logic        busy_i = 1'b0;
   logic        wel_set_i = 1'b0;
   logic        wel_clr_i = 1'b0;
   logic        sr_wr_req_i = 1'b0;
   logic [7:0]  sr_wr_data_i = 8'h00;
   logic        arr_wr_req_i = 1'b0;
   logic [16:0] arr_addr_i = '0;
   logic [7:0]  status_o;
   logic        sr_wr_ok_o;
   logic        arr_wr_ok_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   eewp_ctrl u_eewp_ctrl (.*);

   // {level[1:0], address[16:0], expected permit}
   localparam logic [19:0] VEC [12] = '{
      {2'b00, 17'h1FFFF, 1'b1}, {2'b00, 17'h00000, 1'b1},
      {2'b01, 17'h17FFF, 1'b1}, {2'b01, 17'h18000, 1'b0},
      {2'b01, 17'h1FFFF, 1'b0}, {2'b01, 17'h00000, 1'b1},
      {2'b10, 17'h0FFFF, 1'b1}, {2'b10, 17'h10000, 1'b0},
      {2'b10, 17'h1FFFF, 1'b0}, {2'b11, 17'h00000, 1'b0},
      {2'b11, 17'h0ABCD, 1'b0}, {2'b11, 17'h1FFFF, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wel_on();
      @(negedge clk); wel_set_i = 1'b1;
      @(negedge clk); wel_set_i = 1'b0;
   endtask

   task automatic sr_write(input logic [7:0] d);
      @(negedge clk); sr_wr_req_i = 1'b1; sr_wr_data_i = d;
      @(negedge clk); sr_wr_req_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R1 reset status", status_o, 8'h00);

      // R2 busy mirror
      busy_i = 1'b1; #1;
      chk("R2 busy bit", status_o[0], 1'b1);
      busy_i = 1'b0;

      // R3 latch set, clear, and clear-wins
      wel_on(); #1;
      chk("R3 wel set", status_o[1], 1'b1);
      @(negedge clk); wel_clr_i = 1'b1;
      @(negedge clk); wel_clr_i = 1'b0; #1;
      chk("R3 wel clear", status_o[1], 1'b0);
      @(negedge clk); wel_set_i = 1'b1; wel_clr_i = 1'b1;
      @(negedge clk); wel_set_i = 1'b0; wel_clr_i = 1'b0; #1;
      chk("R3 clear wins", status_o[1], 1'b0);

      // R7 refused without latch
      @(negedge clk); sr_wr_req_i = 1'b1; sr_wr_data_i = 8'h8C; #2;
      chk("R7 no latch refuse", sr_wr_ok_o, 1'b0);
      @(negedge clk); sr_wr_req_i = 1'b0; #1;
      chk("R9 refused unchanged", status_o, 8'h00);

      // R4 decode table
      for (int i = 0; i < 12; i++) begin
         wel_on();
         sr_write({4'b0000, VEC[i][19:18], 2'b00});
         wel_on();
         @(negedge clk); arr_wr_req_i = 1'b1; arr_addr_i = VEC[i][17:1]; #2;
         chk($sformatf("R4 vec %0d", i), arr_wr_ok_o, VEC[i][0]);
         arr_wr_req_i = 1'b0;
      end
      @(negedge clk); wel_clr_i = 1'b1;
      @(negedge clk); wel_clr_i = 1'b0;

      // R7 accepted with pin low, flag clear; spare bits ignored
      wel_on();
      @(negedge clk); wp_n_i = 1'b0; sr_wr_req_i = 1'b1; sr_wr_data_i = 8'hFC; #2;
      chk("R7 accept pin low flag off", sr_wr_ok_o, 1'b1);
      @(negedge clk); sr_wr_req_i = 1'b0; #1;
      chk("R7 R2 R9 stored byte", status_o, 8'h8C);

      // R6 lock refuses; R8 flag sticks
      wel_on();
      @(negedge clk); sr_wr_req_i = 1'b1; sr_wr_data_i = 8'h00; #2;
      chk("R6 locked refuse", sr_wr_ok_o, 1'b0);
      @(negedge clk); sr_wr_req_i = 1'b0; #1;
      chk("R8 R9 flag sticky unchanged", status_o, 8'h8E);

      // R4 full level blocks array
      @(negedge clk); arr_wr_req_i = 1'b1; arr_addr_i = 17'h00000; #2;
      chk("R4 full level", arr_wr_ok_o, 1'b0);
      arr_wr_req_i = 1'b0;

      // unlock with pin high, set quarter level with flag on
      @(negedge clk); wp_n_i = 1'b1; sr_wr_req_i = 1'b1; sr_wr_data_i = 8'h84; #2;
      chk("R6 pin high unlocks", sr_wr_ok_o, 1'b1);
      @(negedge clk); sr_wr_req_i = 1'b0; #1;
      chk("R7 new level", status_o, 8'h84);

      // R5 pin low does not block the array; R10 priority
      wel_on();
      @(negedge clk); wp_n_i = 1'b0; sr_wr_req_i = 1'b1; arr_wr_req_i = 1'b1;
      arr_addr_i = 17'h00100; #2;
      chk("R10 sr request blocks array", arr_wr_ok_o, 1'b0);
      sr_wr_req_i = 1'b0; #1;
      chk("R5 pin low array ok", arr_wr_ok_o, 1'b1);
      @(negedge clk); arr_wr_req_i = 1'b0; #1;
      chk("R9 array write consumes latch", status_o, 8'h84);
      @(negedge clk); arr_wr_req_i = 1'b1; #2;
      chk("R5 no latch no array", arr_wr_ok_o, 1'b0);
      arr_wr_req_i = 1'b0;

      // clear everything, then R10 with an accepted status write
      @(negedge clk); wp_n_i = 1'b1;
      wel_on();
      sr_write(8'h00); #1;
      chk("R7 flag cleared with pin high", status_o, 8'h00);
      wel_on();
      @(negedge clk); sr_wr_req_i = 1'b1; sr_wr_data_i = 8'h00; arr_wr_req_i = 1'b1; #2;
      chk("R10 sr granted", sr_wr_ok_o, 1'b1);
      chk("R10 array withheld", arr_wr_ok_o, 1'b0);
      @(negedge clk); sr_wr_req_i = 1'b0; arr_wr_req_i = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule